// File: doc/BRIEF.md
# Power-Good Strap Latch Sequencer

This block sequences the start-up of a clock generator and captures its frequency-select straps exactly once. After an asynchronous power-on reset it leaves the off phase, waits a settling interval, then waits for an active-low power-good strobe from the processor supply. While the strobe is seen low, it latches the two straps into a frequency code. It then counts a start-up interval and enables the outputs. After the capture, any movement of the strobe or the straps is ignored until the next power-on reset.

When the second strap is reported at its mid level at the moment of capture, the block locks into a test-clock mode. In that mode the second strap no longer matters. The first strap then steers, with no clock involved, between placing all outputs in high impedance and running them at the reference divided by N. Only a new power-on reset leaves test mode. The tri-level detection happens outside the block and arrives as a qualifier bit. All intervals are counted in cycles of the free-running reference clock. The strobe and the straps pass through a synchronizer before the sequencer uses them.

Top module: `pwrgd_strap_seq`

## Requirements
- R1: While `por_n` is low, `seq_phase` is 0 (off), and `out_en`, `freq_code`, `test_mode`, `hiz_sel` and `cpu_mhz` are all 0.
- R2: The first clock edge after `por_n` rises moves `seq_phase` to 1 (settle). The block stays in settle for SETTLE_CYC edges and then moves to 2 (sample).
- R3: In sample, the capture happens on the first edge at which the synchronized strobe is low. An input change lands at the synchronizer output SYNC_STAGES edges later, so the capture edge is the later of (entry to sample + 1) and (strobe drive edge + SYNC_STAGES + 1). A low pulse on the strobe that ends before the sample phase is missed. The capture moves `seq_phase` to 3 (start-up).
- R4: The captured code is `freq_code` = {strap_b, strap_a}, with bit 1 from strap_b and bit 0 from strap_a, taken at the capture edge.
- R5: After the capture, changes on `vtt_good_n`, `strap_a`, `strap_b` and `strap_b_mid` have no effect on `freq_code`, `test_mode` or `seq_phase`.
- R6: Start-up lasts STARTUP_CYC edges, then `seq_phase` becomes 4 (run). `out_en` is 1 exactly in run, and run is held until reset.
- R7: Once the code is captured outside test mode, `cpu_mhz` decodes it. With `alt_table` = 0: 00→100, 01→133, 10→200, 11→0. With `alt_table` = 1: 00→200, 01→400, 10→266, 11→0. `alt_table` is read live. Before the capture and in test mode, `cpu_mhz` is 0.
- R8: If `strap_b_mid` is 1 at the capture edge, `test_mode` becomes 1 and `freq_code` is forced to 00, whatever `strap_b` is.
- R9: In test mode, `hiz_sel` follows `strap_a` combinationally, with no clock edge: 1 selects high impedance and 0 selects reference divided by N. Outside test mode `hiz_sel` is 0.
- R10: Test mode is left only through `por_n`. A new power-up with `strap_b_mid` = 0 at capture gives `test_mode` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| vtt_good_n | input | 1 | Processor supply good strobe, active low |
| strap_a | input | 1 | First frequency-select strap |
| strap_b | input | 1 | Second frequency-select strap |
| strap_b_mid | input | 1 | Second strap detected at mid level |
| alt_table | input | 1 | Selects the alternate frequency table |
| seq_phase | output | 3 | Phase: 0 off, 1 settle, 2 sample, 3 start-up, 4 run |
| freq_code | output | 2 | Latched frequency code |
| cpu_mhz | output | 9 | Decoded CPU frequency in MHz, 0 when not valid |
| test_mode | output | 1 | Test-clock mode latched |
| hiz_sel | output | 1 | Test mode: 1 high impedance, 0 reference divided by N |
| out_en | output | 1 | Clock outputs enabled |

## Verification
The bench places the strobe both well before and after the end of the settle phase. A design that compared against the wrong synchronizer depth, or that captured during settle, would then shift the capture edge by one or more cycles. A low pulse that ends inside settle must not be captured, or the design would latch too early. After each run the bench moves the strobe, the straps and the mid qualifier at random. This exposes a latch that stays transparent or a test flag that can be set again. In test mode the bench toggles the first strap between clock edges and toggles the second strap, to catch a registered Hi-Z path or a code that still takes the second strap.

// File: rtl/strap_pkg.sv
package strap_pkg;

  typedef enum logic [2:0] {
    PH_OFF     = 3'd0,
    PH_SETTLE  = 3'd1,
    PH_SAMPLE  = 3'd2,
    PH_STARTUP = 3'd3,
    PH_RUN     = 3'd4
  } phase_e;

  localparam int MHZ_W = 9;

  // Bit order of the synchronized input bundle.
  localparam int SB_A      = 0;
  localparam int SB_B      = 1;
  localparam int SB_MID    = 2;
  localparam int SB_STROBE = 3;
  localparam int SB_W      = 4;

  function automatic logic [MHZ_W-1:0] cpu_mhz_of(input logic [1:0] code,
                                                  input logic alt);
    logic [MHZ_W-1:0] f;
    unique case ({alt, code})
      3'b000:  f = MHZ_W'(100);
      3'b001:  f = MHZ_W'(133);
      3'b010:  f = MHZ_W'(200);
      3'b100:  f = MHZ_W'(200);
      3'b101:  f = MHZ_W'(400);
      3'b110:  f = MHZ_W'(266);
      default: f = '0;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int               WIDTH   = 4,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[s] <= RST_VAL;
        else        pipe[s] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[s] <= RST_VAL;
        else        pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/strap_timer.sv
module strap_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  assign done = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            cnt_q <= '0;
    else if (!run || done) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= limit));
endmodule

// File: rtl/strap_capture.sv
module strap_capture (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       a_s,
  input  logic       b_s,
  input  logic       mid_s,
  output logic [1:0] code_q,
  output logic       test_q
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      code_q <= 2'b00;
      test_q <= 1'b0;
    end else if (take) begin
      code_q <= mid_s ? 2'b00 : {b_s, a_s};
      test_q <= mid_s;
    end

  assert_test_only_on_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_q) |-> $past(take));
endmodule

// File: rtl/pwrgd_strap_seq.sv
module pwrgd_strap_seq
  import strap_pkg::*;
#(
  parameter int SETTLE_CYC  = 3580,
  parameter int STARTUP_CYC = 25773,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_ref,
  input  logic             por_n,
  input  logic             vtt_good_n,
  input  logic             strap_a,
  input  logic             strap_b,
  input  logic             strap_b_mid,
  input  logic             alt_table,
  output logic [2:0]       seq_phase,
  output logic [1:0]       freq_code,
  output logic [MHZ_W-1:0] cpu_mhz,
  output logic             test_mode,
  output logic             hiz_sel,
  output logic             out_en
);
  localparam int MAX_CYC = (SETTLE_CYC > STARTUP_CYC) ? SETTLE_CYC : STARTUP_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] SETTLE_LIM  = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] STARTUP_LIM = CNT_W'(STARTUP_CYC - 1);
  localparam logic [SB_W-1:0]  SYNC_RST    = SB_W'(1) << SB_STROBE;

  phase_e          phase_q, phase_nxt;
  logic [SB_W-1:0] raw_bus, sync_bus;
  logic            strobe_low_s;
  logic            timer_run, timer_done;
  logic [CNT_W-1:0] timer_limit;
  logic            take, captured;
  logic [1:0]      code_q;
  logic            test_q;

  // Input synchronizer bundle
  always_comb begin
    raw_bus            = '0;
    raw_bus[SB_A]      = strap_a;
    raw_bus[SB_B]      = strap_b;
    raw_bus[SB_MID]    = strap_b_mid;
    raw_bus[SB_STROBE] = vtt_good_n;
  end

  strap_sync #(.WIDTH(SB_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk_ref),
    .rst_n (por_n),
    .d     (raw_bus),
    .q     (sync_bus)
  );

  assign strobe_low_s = !sync_bus[SB_STROBE];

  // Interval timer shared by settle and start-up
  assign timer_run   = (phase_q == PH_SETTLE) || (phase_q == PH_STARTUP);
  assign timer_limit = (phase_q == PH_SETTLE) ? SETTLE_LIM : STARTUP_LIM;

  strap_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk_ref),
    .rst_n (por_n),
    .run   (timer_run),
    .limit (timer_limit),
    .done  (timer_done)
  );

  // Phase sequencer
  always_comb begin
    phase_nxt = phase_q;
    unique case (phase_q)
      PH_OFF:     phase_nxt = PH_SETTLE;
      PH_SETTLE:  if (timer_done)   phase_nxt = PH_SAMPLE;
      PH_SAMPLE:  if (strobe_low_s) phase_nxt = PH_STARTUP;
      PH_STARTUP: if (timer_done)   phase_nxt = PH_RUN;
      PH_RUN:     phase_nxt = PH_RUN;
      default:    phase_nxt = PH_OFF;
    endcase
  end

  always_ff @(posedge clk_ref or negedge por_n)
    if (!por_n) phase_q <= PH_OFF;
    else        phase_q <= phase_nxt;

  assign take     = (phase_q == PH_SAMPLE) && strobe_low_s;
  assign captured = (phase_q == PH_STARTUP) || (phase_q == PH_RUN);

  strap_capture u_cap (
    .clk    (clk_ref),
    .rst_n  (por_n),
    .take   (take),
    .a_s    (sync_bus[SB_A]),
    .b_s    (sync_bus[SB_B]),
    .mid_s  (sync_bus[SB_MID]),
    .code_q (code_q),
    .test_q (test_q)
  );

  // Outputs
  assign seq_phase = phase_q;
  assign freq_code = code_q;
  assign test_mode = test_q;
  assign hiz_sel   = test_q & strap_a;
  assign out_en    = (phase_q == PH_RUN);
  assign cpu_mhz   = (captured && !test_q) ? cpu_mhz_of(code_q, alt_table) : '0;

  // Assertions
  assert_off_leaves_R2: assert property (@(posedge clk_ref) disable iff (!por_n)
    (phase_q == PH_OFF) |=> (phase_q == PH_SETTLE));

  assert_settle_next_R2: assert property (@(posedge clk_ref) disable iff (!por_n)
    (phase_q == PH_SETTLE) |=> (phase_q == PH_SETTLE || phase_q == PH_SAMPLE));

  assert_capture_leaves_sample_R3: assert property (@(posedge clk_ref) disable iff (!por_n)
    take |=> (phase_q == PH_STARTUP));

  assert_code_frozen_R5: assert property (@(posedge clk_ref) disable iff (!por_n)
    captured |=> ($stable(code_q) && $stable(test_q)));

  assert_run_sticky_R6: assert property (@(posedge clk_ref) disable iff (!por_n)
    out_en |=> out_en);

  assert_test_from_sample_R8: assert property (@(posedge clk_ref) disable iff (!por_n)
    $rose(test_q) |-> ($past(phase_q) == PH_SAMPLE));

  assert_no_freq_early_R7: assert property (@(posedge clk_ref) disable iff (!por_n)
    (phase_q == PH_SETTLE || phase_q == PH_SAMPLE) |-> (cpu_mhz == '0));
endmodule

// File: tb/tb_pwrgd_strap_seq.sv
module tb_pwrgd_strap_seq;
  localparam int N    = 12;
  localparam int M    = 18;
  localparam int SYNC = 2;

  logic       clk_ref = 1'b0;
  logic       por_n = 1'b0;
  logic       vtt_good_n = 1'b1;
  logic       strap_a = 1'b0, strap_b = 1'b0, strap_b_mid = 1'b0, alt_table = 1'b0;
  logic [2:0] seq_phase;
  logic [1:0] freq_code;
  logic [8:0] cpu_mhz;
  logic       test_mode, hiz_sel, out_en;

  int n_chk = 0, n_fail = 0, ecnt = 0;
  bit done = 0;

  always #2 clk_ref = ~clk_ref;

  pwrgd_strap_seq #(.SETTLE_CYC(N), .STARTUP_CYC(M), .SYNC_STAGES(SYNC)) dut (
    .clk_ref(clk_ref), .por_n(por_n), .vtt_good_n(vtt_good_n),
    .strap_a(strap_a), .strap_b(strap_b), .strap_b_mid(strap_b_mid),
    .alt_table(alt_table), .seq_phase(seq_phase), .freq_code(freq_code),
    .cpu_mhz(cpu_mhz), .test_mode(test_mode), .hiz_sel(hiz_sel), .out_en(out_en)
  );

  function automatic int exp_mhz(input logic [1:0] code, input logic alt);
    int t0 [4] = '{100, 133, 200, 0};
    int t1 [4] = '{200, 400, 266, 0};
    return alt ? t1[code] : t0[code];
  endfunction

  function automatic int cap_edge(input int k);
    int a = N + 2;
    int b = k + SYNC + 1;
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_ref);
    @(negedge clk_ref);
    ecnt++;
  endtask

  task automatic power_up();
    @(negedge clk_ref);
    por_n = 1'b0;
    #1;
    chk("R1", "phase", int'(seq_phase), 0);
    chk("R1", "out_en", int'(out_en), 0);
    chk("R1", "freq_code", int'(freq_code), 0);
    chk("R1", "test_mode R10", int'(test_mode), 0);
    chk("R1", "hiz_sel", int'(hiz_sel), 0);
    chk("R1", "cpu_mhz", int'(cpu_mhz), 0);
    @(negedge clk_ref);
    @(negedge clk_ref);
    por_n = 1'b1;
    ecnt = 0;
  endtask

  task automatic run_case(input logic a, input logic b, input logic mid,
                          input logic alt, input int k);
    logic [1:0] code_e = mid ? 2'b00 : {b, a};
    int p = cap_edge(k);
    strap_a = a; strap_b = b; strap_b_mid = mid; alt_table = alt; vtt_good_n = 1'b1;
    power_up();
    for (int e = 0; e <= p + M; e++) begin
      if (e > 0) step();
      if (e == k) vtt_good_n = 1'b0;
      if (e == N)     chk("R2", "phase in settle", int'(seq_phase), 1);
      if (e == N + 1) chk("R2", "phase in sample", int'(seq_phase), 2);
      if (e == p - 1) chk("R3", "phase before capture", int'(seq_phase), 2);
      if (e == p) begin
        chk("R3", "phase after capture", int'(seq_phase), 3);
        chk(mid ? "R8" : "R4", "freq_code", int'(freq_code), int'(code_e));
        chk("R8", "test_mode", int'(test_mode), int'(mid));
      end
      if (e == p + M - 1) chk("R6", "out_en before run", int'(out_en), 0);
      if (e == p + M) begin
        chk("R6", "out_en in run", int'(out_en), 1);
        chk("R6", "phase run", int'(seq_phase), 4);
        chk("R7", "cpu_mhz", int'(cpu_mhz), mid ? 0 : exp_mhz(code_e, alt));
      end
    end
    for (int i = 0; i < 8; i++) begin
      step();
      vtt_good_n = 1'($urandom); strap_a = 1'($urandom);
      strap_b = 1'($urandom); strap_b_mid = 1'($urandom);
    end
    step();
    chk("R5", "freq_code frozen", int'(freq_code), int'(code_e));
    chk("R5", "test_mode frozen", int'(test_mode), int'(mid));
    chk("R5", "phase frozen", int'(seq_phase), 4);
    alt_table = ~alt;
    #1;
    chk("R7", "cpu_mhz alt live", int'(cpu_mhz), mid ? 0 : exp_mhz(code_e, ~alt));
    strap_a = 1'b1;
    #1;
    chk("R9", "hiz_sel strap high", int'(hiz_sel), int'(mid));
    strap_a = 1'b0;
    #1;
    chk("R9", "hiz_sel strap low", int'(hiz_sel), 0);
  endtask

  task automatic missed_pulse();
    int p;
    strap_a = 1'b1; strap_b = 1'b0; strap_b_mid = 1'b0; alt_table = 1'b0; vtt_good_n = 1'b1;
    power_up();
    for (int e = 0; e <= N + 8; e++) begin
      if (e > 0) step();
      if (e == 1) vtt_good_n = 1'b0;
      if (e == 3) vtt_good_n = 1'b1;
    end
    chk("R3", "pulse in settle missed", int'(seq_phase), 2);
    chk("R3", "no code after missed pulse", int'(freq_code), 0);
    vtt_good_n = 1'b0;
    p = ecnt + SYNC + 1;
    while (ecnt < p) step();
    chk("R3", "late strobe captured", int'(seq_phase), 3);
    chk("R4", "late strobe code", int'(freq_code), 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // Directed corners
    missed_pulse();
    run_case(1'b0, 1'b0, 1'b0, 1'b0, 0);
    run_case(1'b1, 1'b0, 1'b0, 1'b1, 20);
    run_case(1'b0, 1'b1, 1'b0, 1'b0, N);
    run_case(1'b1, 1'b1, 1'b0, 1'b0, 5);
    run_case(1'b1, 1'b1, 1'b1, 1'b0, 8);   // R8 mid with strap_b high
    run_case(1'b0, 1'b1, 1'b0, 1'b1, 3);   // R10 power cycle leaves test mode
    // Random cases
    for (int i = 0; i < 40; i++)
      run_case(1'($urandom), 1'($urandom), ($urandom % 4) == 0, 1'($urandom),
               int'($urandom % 31));
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_ref);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule